// File: doc/BRIEF.md
# Integer ALU with Sticky Overflow Flags

This block is the integer datapath of a load-store processor. In one cycle it produces the result of an add, a subtract-from, a negate, an add of a sign-extended or upper-placed immediate, or an arithmetic right shift. It can also compare two operands as signed numbers. The result leaves the block combinationally. Next to the datapath sit a 3-bit exception register and a 4-bit condition field. The exception register holds a sticky overflow summary, an overflow bit and a carry bit. The condition field holds less-than, greater-than, equal and a copy of the summary bit. Both are updated on the clock edge that accepts an instruction.

Per-instruction modifier inputs choose what is recorded. A carry is recorded only on request, and the carry-extended forms also read the stored carry as their carry input. An overflow is recorded only on request. The condition field is written only on request. The summary bit, once set, is cleared only by a direct write to the exception register or by the move-to-condition operation. The move-to-condition operation moves the three exception bits into the condition field and then clears them.

Top module: `int_alu_flags`

## Requirements
- R1: The opcode `opc` selects the operation: 0 add (A+B), 1 subtract-from (B+~A+1), 2 negate (~A+1), 3 add-immediate (A plus the immediate sign-extended to 32 bits), 4 add-immediate-shifted (A plus the immediate in bits 31:16 with zeros in bits 15:0), 5 arithmetic shift right, 6 signed compare, 7 move-to-condition. Codes 8 to 15 have no effect on any state. `result` shows the value combinationally and is zero for codes 6 and 7.
- R2: CA (`xer_q[0]`) takes the carry out of bit 31 when codes 0 to 2 carry `rec_ca`, and when codes 0 or 1 carry `use_ca`. With `use_ca`, codes 0 and 1 take the stored CA as their carry input instead of 0 or 1. Without either modifier, CA is unchanged.
- R3: When codes 0 to 2 carry `rec_ov`, OV (`xer_q[1]`) is set if the carry out of bit 31 differs from the carry into bit 31, and cleared otherwise. Without `rec_ov`, OV is unchanged.
- R4: SO (`xer_q[2]`) is set when an instruction sets OV. It stays set through every later instruction except move-to-condition, until a direct write clears it.
- R5: Code 5 shifts A right by B[4:0], filling with the sign bit. CA is set only if A is negative and at least one 1 bit is shifted out, and is cleared otherwise.
- R6: With `upd_cr`, codes 0 to 5 write `cr_q`: bit 0 is set when the result is negative, bit 1 when it is positive and nonzero, bit 2 when it is zero, and bit 3 takes SO as it stands after the instruction. Without `upd_cr`, `cr_q` is unchanged.
- R7: Code 6 with `upd_cr` sets exactly one of bits 0, 1 and 2 of `cr_q` from the signed comparison of A with B, and copies the current SO into bit 3. Code 6 never changes CA, OV or SO.
- R8: Code 7 writes `cr_q` with bit 0 = SO, bit 1 = OV, bit 2 = CA and bit 3 = 0, whatever the value of `upd_cr`, and clears SO, OV and CA.
- R9: A direct write (`xw_en`) loads SO from `xw_data[2]`, OV from `xw_data[1]` and CA from `xw_data[0]`. An instruction issued in the same cycle is ignored, and `cr_q` is unchanged.
- R10: After reset, `xer_q` and `cr_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | An instruction is presented this cycle |
| opc | input | 4 | Operation code |
| opa | input | DATA_W | Operand A |
| opb | input | DATA_W | Operand B; its low bits give the shift amount |
| imm | input | IMM_W | Immediate field |
| rec_ca | input | 1 | Record the carry into CA |
| use_ca | input | 1 | Use CA as the carry input and record the carry |
| rec_ov | input | 1 | Record the overflow into OV and SO |
| upd_cr | input | 1 | Write the condition field |
| xw_en | input | 1 | Direct write of the exception register |
| xw_data | input | 3 | Direct write value: {SO, OV, CA} |
| result | output | DATA_W | Combinational result |
| xer_q | output | 3 | Exception register: {SO, OV, CA} |
| cr_q | output | 4 | Condition field: {SO copy, EQ, GT, LT} |

## Verification
The bench builds the block with its default 32-bit datapath and 16-bit immediate. At that width the signed boundary at 0x7FFFFFFF and the all-ones carry case can be reached directly. The add-immediate-shifted form lands exactly on the upper half-word. Shift amounts up to 31 exercise every stage of the shifter and every lost-bit path. A model in the bench follows each instruction through the summary bit's stickiness and the move-to-condition clearing, so a flag value that is wrong several instructions later is still caught.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUBF  = 4'd1,
      OP_NEG   = 4'd2,
      OP_ADDI  = 4'd3,
      OP_ADDIS = 4'd4,
      OP_SRA   = 4'd5,
      OP_CMP   = 4'd6,
      OP_MCRX  = 4'd7
   } alu_op_e;

   localparam int XER_W = 3;
   localparam int CR_W  = 4;
   localparam int XER_SO = 2;
   localparam int XER_OV = 1;
   localparam int XER_CA = 0;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   generate
      if (W < 2) begin : g_bad_w
         $error("alu_adder: W must be at least 2");
      end
   endgenerate

   logic [W:0] full;
   logic       c_into_msb;

   assign full       = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
   assign sum        = full[W-1:0];
   assign cout       = full[W];
   assign c_into_msb = x[W-1] ^ y[W-1] ^ sum[W-1];
   assign ovf        = cout ^ c_into_msb;
endmodule

// File: rtl/alu_sra.sv
module alu_sra #(
   parameter int W = 32,
   localparam int SH_W = $clog2(W)
) (
   input  logic [W-1:0]    a,
   input  logic [SH_W-1:0] amt,
   output logic [W-1:0]    res,
   output logic            ca
);
   generate
      if ((1 << SH_W) != W) begin : g_bad_w
         $error("alu_sra: W must be a power of two");
      end
   endgenerate

   logic [SH_W:0][W-1:0] stg;
   logic [SH_W:0]        lost;

   assign stg[0]  = a;
   assign lost[0] = 1'b0;

   generate
      for (genvar i = 0; i < SH_W; i++) begin : g_stage
         localparam int D = 1 << i;
         assign stg[i+1]  = amt[i] ? {{D{a[W-1]}}, stg[i][W-1:D]} : stg[i];
         assign lost[i+1] = lost[i] | (amt[i] & (|stg[i][D-1:0]));
      end
   endgenerate

   assign res = stg[SH_W];
   assign ca  = a[W-1] & lost[SH_W];
endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg
   import alu_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic             mcr,
   input  logic             ca_we,
   input  logic             ca_nx,
   input  logic             ov_we,
   input  logic             ov_nx,
   input  logic             cr_we,
   input  logic [2:0]       cr_lo,
   input  logic             xw_en,
   input  logic [XER_W-1:0] xw_data,
   output logic [XER_W-1:0] xer_q,
   output logic [CR_W-1:0]  cr_q
);
   logic [XER_W-1:0] xer_d;
   logic [CR_W-1:0]  cr_d;

   always_comb begin
      xer_d = xer_q;
      cr_d  = cr_q;
      if (xw_en) begin
         xer_d = xw_data;
      end else if (upd) begin
         if (mcr) begin
            cr_d  = {1'b0, xer_q[XER_CA], xer_q[XER_OV], xer_q[XER_SO]};
            xer_d = '0;
         end else begin
            if (ca_we) xer_d[XER_CA] = ca_nx;
            if (ov_we) begin
               xer_d[XER_OV] = ov_nx;
               if (ov_nx) xer_d[XER_SO] = 1'b1;
            end
            if (cr_we) cr_d = {xer_d[XER_SO], cr_lo};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xer_q <= '0;
         cr_q  <= '0;
      end else begin
         xer_q <= xer_d;
         cr_q  <= cr_d;
      end
   end

   p_so_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xer_q[XER_SO] && !xw_en && !(upd && mcr)) |=> xer_q[XER_SO]);

   p_ov_sets_so_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !xw_en && !mcr && ov_we && ov_nx) |=> (xer_q[XER_SO] && xer_q[XER_OV]));

   p_cr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xw_en || !upd || (!cr_we && !mcr)) |=> $stable(cr_q));

   p_direct_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xw_en |=> (xer_q == $past(xw_data)));

   p_mcr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && mcr && !xw_en) |=> (xer_q == '0));
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
   import alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [3:0]        opc,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [IMM_W-1:0]  imm,
   input  logic              rec_ca,
   input  logic              use_ca,
   input  logic              rec_ov,
   input  logic              upd_cr,
   input  logic              xw_en,
   input  logic [2:0]        xw_data,
   output logic [DATA_W-1:0] result,
   output logic [2:0]        xer_q,
   output logic [3:0]        cr_q
);
   localparam int SH_W = $clog2(DATA_W);
   localparam int LO_W = DATA_W - IMM_W;

   generate
      if (DATA_W <= IMM_W) begin : g_bad_imm
         $error("int_alu_flags: DATA_W must exceed IMM_W");
      end
   endgenerate

   logic is_add, is_subf, is_neg, is_addi, is_addis, is_sra, is_cmp, is_mcr;
   logic arith, imm_op, res_op, accept;

   assign is_add   = (opc == OP_ADD);
   assign is_subf  = (opc == OP_SUBF);
   assign is_neg   = (opc == OP_NEG);
   assign is_addi  = (opc == OP_ADDI);
   assign is_addis = (opc == OP_ADDIS);
   assign is_sra   = (opc == OP_SRA);
   assign is_cmp   = (opc == OP_CMP);
   assign is_mcr   = (opc == OP_MCRX);
   assign arith    = is_add | is_subf | is_neg;
   assign imm_op   = is_addi | is_addis;
   assign res_op   = arith | imm_op | is_sra;
   assign accept   = issue & (res_op | is_cmp | is_mcr);

   logic [DATA_W-1:0] add_x, add_y, add_sum, sra_res;
   logic              add_ci, add_co, add_ov, sra_ca;

   always_comb begin
      add_x  = opa;
      add_y  = opb;
      add_ci = 1'b0;
      case (opc)
         OP_ADD:   add_ci = use_ca ? xer_q[XER_CA] : 1'b0;
         OP_SUBF: begin
            add_x  = ~opa;
            add_ci = use_ca ? xer_q[XER_CA] : 1'b1;
         end
         OP_NEG: begin
            add_x  = ~opa;
            add_y  = '0;
            add_ci = 1'b1;
         end
         OP_ADDI:  add_y = {{LO_W{imm[IMM_W-1]}}, imm};
         OP_ADDIS: add_y = {imm, {LO_W{1'b0}}};
         default: ;
      endcase
   end

   alu_adder #(.W(DATA_W)) u_adder (
      .x    (add_x),
      .y    (add_y),
      .cin  (add_ci),
      .sum  (add_sum),
      .cout (add_co),
      .ovf  (add_ov)
   );

   alu_sra #(.W(DATA_W)) u_sra (
      .a   (opa),
      .amt (opb[SH_W-1:0]),
      .res (sra_res),
      .ca  (sra_ca)
   );

   assign result = is_sra ? sra_res : ((arith | imm_op) ? add_sum : '0);

   logic       cmp_lt, cmp_eq, res_lt, res_eq;
   logic [2:0] cr_lo;

   assign cmp_lt = $signed(opa) < $signed(opb);
   assign cmp_eq = (opa == opb);
   assign res_lt = result[DATA_W-1];
   assign res_eq = (result == '0);
   assign cr_lo  = is_cmp ? {cmp_eq, ~cmp_lt & ~cmp_eq, cmp_lt}
                          : {res_eq, ~res_lt & ~res_eq, res_lt};

   logic ca_we, ca_nx, ov_we, cr_we;

   assign ca_we = (arith & rec_ca) | ((is_add | is_subf) & use_ca) | is_sra;
   assign ca_nx = is_sra ? sra_ca : add_co;
   assign ov_we = arith & rec_ov;
   assign cr_we = upd_cr & (res_op | is_cmp);

   alu_flagreg u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (accept),
      .mcr     (is_mcr),
      .ca_we   (ca_we),
      .ca_nx   (ca_nx),
      .ov_we   (ov_we),
      .ov_nx   (add_ov),
      .cr_we   (cr_we),
      .cr_lo   (cr_lo),
      .xw_en   (xw_en),
      .xw_data (xw_data),
      .xer_q   (xer_q),
      .cr_q    (cr_q)
   );

   p_cmp_keeps_xer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !xw_en && opc == OP_CMP) |=> $stable(xer_q));

   p_cmp_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !xw_en && upd_cr && opc == OP_CMP) |=> ($countones(cr_q[2:0]) == 1));

   p_no_carry_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !xw_en && (opc == OP_ADD || opc == OP_SUBF) && !rec_ca && !use_ca)
      |=> $stable(xer_q[XER_CA]));
endmodule

// File: tb/int_alu_flags_tb.sv
module int_alu_flags_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [3:0]  opc = '0;
   logic [31:0] opa = '0, opb = '0;
   logic [15:0] imm = '0;
   logic        rec_ca = 0, use_ca = 0, rec_ov = 0, upd_cr = 0, xw_en = 0;
   logic [2:0]  xw_data = '0;
   logic [31:0] result;
   logic [2:0]  xer_q;
   logic [3:0]  cr_q;

   int n_chk = 0;
   int n_fail = 0;

   logic [6:0] q_st[$];
   string      q_req[$];

   logic m_so = 0, m_ov = 0, m_ca = 0;
   logic [3:0] m_cr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   int_alu_flags u_dut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .opc(opc), .opa(opa), .opb(opb),
      .imm(imm), .rec_ca(rec_ca), .use_ca(use_ca), .rec_ov(rec_ov), .upd_cr(upd_cr),
      .xw_en(xw_en), .xw_data(xw_data), .result(result), .xer_q(xer_q), .cr_q(cr_q)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // monitor: compares registered state one clock after each driven item
   always @(negedge clk) begin
      if (q_st.size() > 0) begin
         logic [6:0] e;
         string r;
         e = q_st.pop_front();
         r = q_req.pop_front();
         check(r, "xer", {29'd0, xer_q}, {29'd0, e[6:4]});
         check(r, "cr", {28'd0, cr_q}, {28'd0, e[3:0]});
      end
   end

   // driver: applies one instruction, checks the result, pushes expected state
   task automatic step(input string req, input logic iss, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                       input logic rc, input logic uc, input logic ro, input logic ucr,
                       input logic we, input logic [2:0] wd);
      logic [31:0] x, y, r;
      logic [32:0] full;
      logic        ci, ovf, lost;
      int          sh;
      @(negedge clk);
      #1;
      issue = iss; opc = op; opa = a; opb = b; imm = im;
      rec_ca = rc; use_ca = uc; rec_ov = ro; upd_cr = ucr; xw_en = we; xw_data = wd;
      r = '0;
      case (op)
         4'd0, 4'd1, 4'd2: begin
            x  = (op == 4'd0) ? a : ~a;
            y  = (op == 4'd2) ? 32'd0 : b;
            ci = (op == 4'd0) ? 1'b0 : 1'b1;
            if (uc && op != 4'd2) ci = m_ca;
            full = {1'b0, x} + {1'b0, y} + {32'd0, ci};
            r    = full[31:0];
            ovf  = (x[31] == y[31]) && (r[31] != x[31]);
         end
         4'd3: r = a + {{16{im[15]}}, im};
         4'd4: r = a + {im, 16'h0000};
         4'd5: begin
            sh   = int'(b[4:0]);
            r    = $signed(a) >>> sh;
            lost = ((a & ((32'h1 << sh) - 32'h1)) != 0);
         end
         default: r = '0;
      endcase
      #1;
      if (!we && op <= 4'd7) check(req, "result", result, r);
      if (we) begin
         {m_so, m_ov, m_ca} = wd;
      end else if (iss && op <= 4'd7) begin
         if (op == 4'd7) begin
            m_cr = {1'b0, m_ca, m_ov, m_so};
            {m_so, m_ov, m_ca} = 3'b000;
         end else begin
            if (op <= 4'd2) begin
               if (rc || (uc && op != 4'd2)) m_ca = full[32];
               if (ro) begin
                  m_ov = ovf;
                  if (ovf) m_so = 1'b1;
               end
            end
            if (op == 4'd5) m_ca = a[31] && lost;
            if (ucr) begin
               if (op == 4'd6)
                  m_cr = {m_so, a == b, $signed(a) > $signed(b), $signed(a) < $signed(b)};
               else
                  m_cr = {m_so, r == 0, !r[31] && r != 0, r[31]};
            end
         end
      end
      q_st.push_back({m_so, m_ov, m_ca, m_cr});
      q_req.push_back(req);
   endtask

   task automatic idle(string req);
      step(req, 1'b0, 4'd0, 32'd0, 32'd0, 16'd0, 0, 0, 0, 0, 0, 3'b000);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog act=hung exp=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle("R10 reset state");
      // R1 plain add, R6 positive result
      step("R1 R6 add", 1, 4'd0, 32'd5, 32'd7, 16'd0, 0, 0, 0, 1, 0, 3'b0);
      // R3 R4 signed overflow sets OV and SO, R6 negative result with SO copy
      step("R3 R4 add overflow", 1, 4'd0, 32'h7FFF_FFFF, 32'd1, 16'd0, 0, 0, 1, 1, 0, 3'b0);
      // R3 OV cleared, R4 SO stays
      step("R3 R4 no overflow", 1, 4'd0, 32'd1, 32'd2, 16'd0, 0, 0, 1, 0, 0, 3'b0);
      // R2 carry out recorded, R6 zero result
      step("R2 R6 add carrying", 1, 4'd0, 32'hFFFF_FFFF, 32'd1, 16'd0, 1, 0, 0, 1, 0, 3'b0);
      // R2 extended form uses CA as carry input
      step("R2 add extended", 1, 4'd0, 32'd0, 32'd0, 16'd0, 0, 1, 0, 0, 0, 3'b0);
      // R2 carry not recorded without modifier
      step("R2 no record", 1, 4'd0, 32'hFFFF_FFFF, 32'd3, 16'd0, 0, 0, 0, 0, 0, 3'b0);
      // R1 R2 subtract-from with carry record
      step("R1 R2 subf", 1, 4'd1, 32'd3, 32'd10, 16'd0, 1, 0, 0, 1, 0, 3'b0);
      step("R1 R2 subf borrow", 1, 4'd1, 32'd10, 32'd3, 16'd0, 1, 0, 0, 1, 0, 3'b0);
      // R1 negate
      step("R1 neg", 1, 4'd2, 32'd5, 32'd0, 16'd0, 0, 0, 1, 1, 0, 3'b0);
      // R1 immediates
      step("R1 addi sext", 1, 4'd3, 32'd1, 32'd0, 16'hF000, 1, 1, 1, 1, 0, 3'b0);
      step("R1 addis", 1, 4'd4, 32'h0000_1000, 32'd0, 16'h1000, 0, 0, 0, 1, 0, 3'b0);
      // R5 shift right algebraic
      step("R5 sra neg lost", 1, 4'd5, 32'hFFFF_FF05, 32'd4, 16'd0, 0, 0, 0, 1, 0, 3'b0);
      step("R5 sra neg clean", 1, 4'd5, 32'h8000_0000, 32'd31, 16'd0, 0, 0, 0, 1, 0, 3'b0);
      step("R5 sra pos lost", 1, 4'd5, 32'h0000_00FF, 32'd4, 16'd0, 0, 0, 0, 1, 0, 3'b0);
      // R9 direct write SO=0 OV=1
      step("R9 direct write", 0, 4'd0, 32'd0, 32'd0, 16'd0, 0, 0, 0, 0, 1, 3'b010);
      // R7 compares
      step("R7 cmp lt", 1, 4'd6, 32'hFFFF_FFFE, 32'd1, 16'd0, 1, 1, 1, 1, 0, 3'b0);
      step("R7 cmp gt", 1, 4'd6, 32'd9, 32'hFFFF_FFFF, 16'd0, 0, 0, 0, 1, 0, 3'b0);
      step("R7 cmp eq", 1, 4'd6, 32'd42, 32'd42, 16'd0, 0, 0, 0, 1, 0, 3'b0);
      // R6 condition untouched without modifier
      step("R6 no update", 1, 4'd0, 32'hFFFF_FFFF, 32'd0, 16'd0, 0, 0, 0, 0, 0, 3'b0);
      // R8 move to condition
      step("R9 load all", 0, 4'd0, 32'd0, 32'd0, 16'd0, 0, 0, 0, 0, 1, 3'b101);
      step("R8 mcrx", 1, 4'd7, 32'd0, 32'd0, 16'd0, 0, 0, 0, 0, 0, 3'b0);
      // R9 write wins over a same-cycle instruction
      step("R9 write vs issue", 1, 4'd0, 32'h7FFF_FFFF, 32'd1, 16'd0, 1, 0, 1, 1, 1, 3'b001);
      // R1 undefined code has no effect
      step("R1 undefined op", 1, 4'd9, 32'h7FFF_FFFF, 32'd1, 16'd0, 1, 1, 1, 1, 0, 3'b0);
      // R4 SO persists across plain instructions
      step("R4 set so", 1, 4'd1, 32'h8000_0000, 32'd0, 16'd0, 0, 0, 1, 1, 0, 3'b0);
      step("R4 sticky", 1, 4'd0, 32'd1, 32'd1, 16'd0, 1, 0, 1, 1, 0, 3'b0);
      idle("R4 drain");
      idle("R10 drain");
      finish_run();
   end
endmodule